// File: doc/BRIEF.md
# E1 Per-Timeslot Channel Control Datapath

This block sits between a 2.048 Mbit/s trunk framer and a time-division backplane. It handles one channel byte per strobe, in both directions. Each of the 32 timeslots has its own control word. The word decides whether that slot's byte is bit-inverted, looped back in one of two ways, replaced by an idle pattern, frozen, or replaced by a test byte. The framer supplies the current timeslot number together with a transmit strobe or a receive strobe. The block answers one clock later with a registered output byte.

On the transmit side, a backplane byte enters and a line byte leaves. On the receive side, a line byte enters and a backplane byte leaves. The block keeps the most recent byte of each timeslot from three streams: the line input, the backplane input and the backplane output. Loopback and freeze read from these stores.

The control words are written through a small write-only port. One global idle-code byte is written through the same port. The test-pattern generators live outside the block: the block only chooses when their bytes are used. It also reports, for the current timeslot, the signalling-source select bit, which a neighbouring signalling multiplexer uses.

Top module: `e1_slot_ctrl`

## Requirements
- R1: After reset, `tx_line` and `bp_out` are 0x00. Every control word and the idle code are also 0, so every byte passes through unchanged.
- R2: A write with `cfg_addr` = 0x90+n (n = 0..31) loads `cfg_wdata[9:1]` into the control word of timeslot n. A write to 0x0A loads `cfg_wdata[7:0]` into the idle code. Writes to any other address change nothing.
- R3: The control word of timeslot 0 always reads as zero: a write to 0x90 has no effect on any path.
- R4: A transmit strobe updates `tx_line` on the next clock edge. Without a transmit strobe, `tx_line` holds its value. With no control bit set, `tx_line` equals `bp_in`.
- R5: Word bit 6 (transmit inversion) XORs the chosen transmit byte with 0x55. This does not apply when the byte comes from remote loopback.
- R6: Word bit 1 (idle substitute) replaces the transmit byte with the idle code. It ranks above the backplane byte.
- R7: Word bit 3 (transmit test) replaces the transmit byte with `tx_test_byte`. It ranks above the idle code.
- R8: Word bit 5 (remote loopback) sends the most recent line byte received in that timeslot to `tx_line`. It has the highest transmit priority, and the receive path still delivers the line byte.
- R9: A receive strobe updates `bp_out` on the next edge, and `bp_out` holds otherwise. The line byte passes through, XORed with 0x55 when word bit 9 (receive inversion) is set.
- R10: Word bit 4 (local loopback) sends the most recent `bp_in` byte of that timeslot to `bp_out`. It has the highest receive priority, and the transmit path is unaffected.
- R11: Word bit 8 (receive freeze) makes `bp_out` repeat the last byte sent out in that timeslot.
- R12: Word bit 2 (receive test) sends `rx_test_byte` to `bp_out`. The receive inversion does not apply to it.
- R13: `cas_src` equals word bit 7 of the timeslot selected by `ts_idx`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| ts_idx | input | 5 | Current timeslot number |
| tx_stb | input | 1 | Transmit byte strobe |
| bp_in | input | 8 | Backplane input byte |
| tx_test_byte | input | 8 | External transmit test byte |
| tx_line | output | 8 | Transmit line byte (registered) |
| rx_stb | input | 1 | Receive byte strobe |
| line_in | input | 8 | Received line byte |
| rx_test_byte | input | 8 | External receive test byte |
| bp_out | output | 8 | Backplane output byte (registered) |
| cas_src | output | 1 | Signalling-source select of current timeslot |

## Verification
Plain pass-through bytes are sent in several timeslots with all words clear. Then each control bit is set alone, and again together with bits of lower priority. The result shows which source won and whether the 0x55 mask was applied after it. Distinct byte values are placed in neighbouring slots and in both directions. Loopback and freeze must then return the byte of their own timeslot and stream, not a neighbour's or a newer one. Writes to timeslot 0, and to addresses just outside the window, separate correct address decoding from an off-by-one decode or a missing guard on slot 0.

// File: rtl/e1sc_pkg.sv
package e1sc_pkg;
  // control word fields, MSB = word bit 9, LSB = word bit 1
  typedef struct packed {
    logic rx_inv;   // bit 9
    logic rx_frz;   // bit 8
    logic cas_sel;  // bit 7
    logic tx_inv;   // bit 6
    logic rlb;      // bit 5
    logic llb;      // bit 4
    logic tx_tst;   // bit 3
    logic rx_tst;   // bit 2
    logic tx_idle;  // bit 1
  } slot_ctl_t;

  localparam int CTL_LSB = 1;
  localparam int CTL_W   = $bits(slot_ctl_t);
endpackage

// File: rtl/e1sc_regfile.sv
module e1sc_regfile
  import e1sc_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int SLOT_BASE = 'h90,
  parameter int IDLE_ADDR = 'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output slot_ctl_t         words [SLOTS],
  output logic [BYTE_W-1:0] idle_code
);
  logic [SLOTS-1:0]  hit;
  logic              idle_hit;
  logic [BYTE_W-1:0] idle_nxt;

  assign idle_hit = we && (addr == ADDR_W'(IDLE_ADDR));
  assign idle_nxt = idle_hit ? wdata[BYTE_W-1:0] : idle_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_code <= '0;
    else        idle_code <= idle_nxt;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign hit[s] = we && (addr == ADDR_W'(SLOT_BASE + s));
    if (s == 0) begin : g_zero
      assign words[s] = '0;
    end else begin : g_reg
      slot_ctl_t q, nxt;
      always_comb begin
        nxt = q;
        if (hit[s]) nxt = slot_ctl_t'(wdata[CTL_LSB +: CTL_W]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
      assign words[s] = q;
    end
  end
endmodule

// File: rtl/e1sc_byte_store.sv
module e1sc_byte_store #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  assign rdata = mem[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/e1sc_tx_path.sv
module e1sc_tx_path
  import e1sc_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] INV_MASK = 8'h55
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  slot_ctl_t    ctl,
  input  logic [W-1:0] bp_byte,
  input  logic [W-1:0] loop_byte,
  input  logic [W-1:0] test_byte,
  input  logic [W-1:0] idle_byte,
  output logic [W-1:0] line_q
);
  logic [W-1:0] src, nxt;

  always_comb begin
    if (ctl.tx_tst)       src = test_byte;
    else if (ctl.tx_idle) src = idle_byte;
    else                  src = bp_byte;
    if (ctl.tx_inv) src = src ^ INV_MASK;
    nxt = line_q;
    if (stb) nxt = ctl.rlb ? loop_byte : src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= nxt;
  end
endmodule

// File: rtl/e1sc_rx_path.sv
module e1sc_rx_path
  import e1sc_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] INV_MASK = 8'h55
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  slot_ctl_t    ctl,
  input  logic [W-1:0] line_byte,
  input  logic [W-1:0] loop_byte,
  input  logic [W-1:0] frz_byte,
  input  logic [W-1:0] test_byte,
  output logic [W-1:0] sel_byte,
  output logic [W-1:0] bp_q
);
  logic [W-1:0] nxt;

  always_comb begin
    if (ctl.llb)         sel_byte = loop_byte;
    else if (ctl.rx_frz) sel_byte = frz_byte;
    else if (ctl.rx_tst) sel_byte = test_byte;
    else if (ctl.rx_inv) sel_byte = line_byte ^ INV_MASK;
    else                 sel_byte = line_byte;
    nxt = stb ? sel_byte : bp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bp_q <= '0;
    else        bp_q <= nxt;
  end
endmodule

// File: rtl/e1_slot_ctrl.sv
module e1_slot_ctrl
  import e1sc_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int SLOT_BASE = 'h90,
  parameter int IDLE_ADDR = 'h0A,
  localparam int TS_W     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [TS_W-1:0]   ts_idx,
  input  logic              tx_stb,
  input  logic [BYTE_W-1:0] bp_in,
  input  logic [BYTE_W-1:0] tx_test_byte,
  output logic [BYTE_W-1:0] tx_line,
  input  logic              rx_stb,
  input  logic [BYTE_W-1:0] line_in,
  input  logic [BYTE_W-1:0] rx_test_byte,
  output logic [BYTE_W-1:0] bp_out,
  output logic              cas_src
);
  localparam logic [BYTE_W-1:0] INV_MASK = BYTE_W'(8'h55);

  slot_ctl_t         words [SLOTS];
  slot_ctl_t         ctl_cur;
  logic [BYTE_W-1:0] idle_code;
  logic [BYTE_W-1:0] line_rd, bpin_rd, out_rd, rx_sel;

  assign ctl_cur = words[ts_idx];
  assign cas_src = ctl_cur.cas_sel;

  e1sc_regfile #(
    .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W),
    .SLOT_BASE(SLOT_BASE), .IDLE_ADDR(IDLE_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .words(words), .idle_code(idle_code)
  );

  // last received line byte per slot (remote loopback source)
  e1sc_byte_store #(.DEPTH(SLOTS), .W(BYTE_W)) u_line_st (
    .clk(clk), .rst_n(rst_n), .we(rx_stb), .waddr(ts_idx),
    .wdata(line_in), .raddr(ts_idx), .rdata(line_rd)
  );

  // last backplane input byte per slot (local loopback source)
  e1sc_byte_store #(.DEPTH(SLOTS), .W(BYTE_W)) u_bpin_st (
    .clk(clk), .rst_n(rst_n), .we(tx_stb), .waddr(ts_idx),
    .wdata(bp_in), .raddr(ts_idx), .rdata(bpin_rd)
  );

  // last backplane output byte per slot (freeze source)
  e1sc_byte_store #(.DEPTH(SLOTS), .W(BYTE_W)) u_out_st (
    .clk(clk), .rst_n(rst_n), .we(rx_stb), .waddr(ts_idx),
    .wdata(rx_sel), .raddr(ts_idx), .rdata(out_rd)
  );

  e1sc_tx_path #(.W(BYTE_W), .INV_MASK(INV_MASK)) u_tx (
    .clk(clk), .rst_n(rst_n), .stb(tx_stb), .ctl(ctl_cur),
    .bp_byte(bp_in), .loop_byte(line_rd), .test_byte(tx_test_byte),
    .idle_byte(idle_code), .line_q(tx_line)
  );

  e1sc_rx_path #(.W(BYTE_W), .INV_MASK(INV_MASK)) u_rx (
    .clk(clk), .rst_n(rst_n), .stb(rx_stb), .ctl(ctl_cur),
    .line_byte(line_in), .loop_byte(bpin_rd), .frz_byte(out_rd),
    .test_byte(rx_test_byte), .sel_byte(rx_sel), .bp_q(bp_out)
  );
endmodule

// File: rtl/e1sc_chk.sv
module e1sc_chk
  import e1sc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int TS_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_stb,
  input logic              rx_stb,
  input logic [TS_W-1:0]   ts_idx,
  input slot_ctl_t         ctl_cur,
  input logic [BYTE_W-1:0] tx_line,
  input logic [BYTE_W-1:0] bp_out,
  input logic [BYTE_W-1:0] line_rd,
  input logic [BYTE_W-1:0] bpin_rd
);
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_stb |=> $stable(tx_line));

  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_stb |=> $stable(bp_out));

  p_slot0_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_idx == '0) |-> (ctl_cur == '0));

  p_remote_lb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stb && ctl_cur.rlb) |=> (tx_line == $past(line_rd)));

  p_local_lb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && ctl_cur.llb) |=> (bp_out == $past(bpin_rd)));
endmodule

bind e1_slot_ctrl e1sc_chk #(.BYTE_W(BYTE_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_stb(tx_stb), .rx_stb(rx_stb),
  .ts_idx(ts_idx), .ctl_cur(ctl_cur), .tx_line(tx_line), .bp_out(bp_out),
  .line_rd(line_rd), .bpin_rd(bpin_rd)
);

// File: tb/sim_e1_slot_ctrl.sv
`timescale 1ns/1ps
module sim_e1_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [4:0]  ts_idx;
  logic        tx_stb, rx_stb;
  logic [7:0]  bp_in, tx_test_byte, line_in, rx_test_byte;
  logic [7:0]  tx_line, bp_out;
  logic        cas_src;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // word bit values
  localparam logic [15:0] B_RINV = 16'h0200, B_FRZ = 16'h0100, B_CAS = 16'h0080,
                          B_TINV = 16'h0040, B_RLB = 16'h0020, B_LLB = 16'h0010,
                          B_TTST = 16'h0008, B_RTST = 16'h0004, B_IDLE = 16'h0002;

  always #2.5 clk = ~clk;

  e1_slot_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ts_idx(ts_idx), .tx_stb(tx_stb), .bp_in(bp_in),
    .tx_test_byte(tx_test_byte), .tx_line(tx_line), .rx_stb(rx_stb),
    .line_in(line_in), .rx_test_byte(rx_test_byte), .bp_out(bp_out),
    .cas_src(cas_src)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tx_byte(input logic [4:0] ts, input logic [7:0] d);
    @(negedge clk);
    ts_idx = ts; bp_in = d; tx_stb = 1'b1;
    @(negedge clk);
    tx_stb = 1'b0;
  endtask

  task automatic rx_byte(input logic [4:0] ts, input logic [7:0] d);
    @(negedge clk);
    ts_idx = ts; line_in = d; rx_stb = 1'b1;
    @(negedge clk);
    rx_stb = 1'b0;
  endtask

  task automatic t_reset;
    check(tx_line, 8'h00, "R1 tx_line after reset");
    check(bp_out, 8'h00, "R1 bp_out after reset");
    tx_byte(5'd3, 8'hA7); check(tx_line, 8'hA7, "R1/R4 pass tx");
    rx_byte(5'd3, 8'h3E); check(bp_out, 8'h3E, "R1/R9 pass rx");
  endtask

  task automatic t_hold;
    tx_byte(5'd6, 8'h81);
    @(negedge clk); ts_idx = 5'd9; bp_in = 8'hFF;
    repeat (3) @(negedge clk);
    check(tx_line, 8'h81, "R4 hold without strobe");
    rx_byte(5'd6, 8'h42);
    @(negedge clk); line_in = 8'h00;
    repeat (3) @(negedge clk);
    check(bp_out, 8'h42, "R9 hold without strobe");
  endtask

  task automatic t_tx_modes;
    wr(8'h0A, 16'h00D5);
    wr(8'h93, B_TTST | B_IDLE | B_TINV);
    tx_test_byte = 8'h0F;
    tx_byte(5'd3, 8'h11); check(tx_line, 8'h0F ^ 8'h55, "R7 test over idle, inverted");
    wr(8'h93, B_IDLE | B_TINV);
    tx_byte(5'd3, 8'h11); check(tx_line, 8'hD5 ^ 8'h55, "R6 idle inverted");
    wr(8'h93, B_IDLE);
    tx_byte(5'd3, 8'h11); check(tx_line, 8'hD5, "R6 idle plain");
    wr(8'h93, B_TINV);
    tx_byte(5'd3, 8'h3C); check(tx_line, 8'h69, "R5 tx inversion");
    tx_byte(5'd4, 8'h3C); check(tx_line, 8'h3C, "R5 neighbour slot clear");
    wr(8'h93, 16'h0000);
  endtask

  task automatic t_rx_modes;
    wr(8'h94, B_RINV);
    rx_byte(5'd4, 8'hF0); check(bp_out, 8'hA5, "R9 rx inversion");
    wr(8'h94, B_RINV | B_RTST);
    rx_test_byte = 8'h5B;
    rx_byte(5'd4, 8'hF0); check(bp_out, 8'h5B, "R12 rx test not inverted");
    wr(8'h94, 16'h0000);
  endtask

  task automatic t_remote;
    rx_byte(5'd5, 8'hA3);
    rx_byte(5'd6, 8'h77);
    wr(8'h95, B_RLB | B_TINV | B_TTST);
    tx_byte(5'd5, 8'h11); check(tx_line, 8'hA3, "R8 remote over test, no inversion");
    rx_byte(5'd5, 8'hC4); check(bp_out, 8'hC4, "R8 rx still line byte");
    tx_byte(5'd5, 8'h11); check(tx_line, 8'hC4, "R8 remote tracks newest byte");
    wr(8'h95, 16'h0000);
  endtask

  task automatic t_local_freeze;
    rx_byte(5'd7, 8'h3C);
    rx_byte(5'd8, 8'h99);
    wr(8'h97, B_FRZ);
    rx_byte(5'd7, 8'h12); check(bp_out, 8'h3C, "R11 freeze repeats slot value");
    rx_byte(5'd8, 8'h21); check(bp_out, 8'h21, "R11 other slot tracks");
    tx_byte(5'd9, 8'h5A);
    wr(8'h99, B_LLB | B_FRZ | B_RTST);
    tx_byte(5'd9, 8'h6B); check(tx_line, 8'h6B, "R10 tx unaffected by local loop");
    rx_byte(5'd9, 8'hFF); check(bp_out, 8'h6B, "R10 local loop wins");
    wr(8'h97, 16'h0000);
    wr(8'h99, 16'h0000);
  endtask

  task automatic t_slot0;
    wr(8'h90, 16'h03FE);
    tx_byte(5'd0, 8'h12); check(tx_line, 8'h12, "R3 slot0 tx unchanged");
    rx_byte(5'd0, 8'h34); check(bp_out, 8'h34, "R3 slot0 rx unchanged");
    check({7'd0, cas_src}, 8'h00, "R3 slot0 cas bit zero");
  endtask

  task automatic t_decode;
    wr(8'hB0, B_TINV);
    wr(8'h8F, B_TINV);
    tx_byte(5'd31, 8'h0F); check(tx_line, 8'h0F, "R2 out-of-window writes ignored");
    wr(8'hAF, B_TINV);
    tx_byte(5'd31, 8'h0F); check(tx_line, 8'h5A, "R2 top slot written");
    tx_byte(5'd30, 8'h0F); check(tx_line, 8'h0F, "R2 slot 30 untouched");
    wr(8'h0B, 16'h0077);
    wr(8'h9E, B_IDLE);
    tx_byte(5'd14, 8'h01); check(tx_line, 8'hD5, "R2 idle code only at 0x0A");
    wr(8'h9E, 16'h0000);
  endtask

  task automatic t_cas;
    wr(8'hA1, B_CAS);
    @(negedge clk); ts_idx = 5'd17; #1;
    check({7'd0, cas_src}, 8'h01, "R13 cas bit slot 17");
    ts_idx = 5'd16; #1;
    check({7'd0, cas_src}, 8'h00, "R13 cas bit slot 16");
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; ts_idx = '0;
    tx_stb = 1'b0; rx_stb = 1'b0; bp_in = '0; line_in = '0;
    tx_test_byte = '0; rx_test_byte = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_hold;
    t_tx_modes;
    t_rx_modes;
    t_remote;
    t_local_freeze;
    t_slot0;
    t_decode;
    t_cas;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule